// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the memory-mapped front end of a platform interrupt controller. It sits between a 32-bit request/response bus and the claim arbiter. It holds the per-source priority table, the per-target enable bitmaps and the per-target threshold registers, and it exports all of them as flat vectors. It reads the pending bitmap from the arbiter. Reads and writes of the per-target claim/complete register become single-cycle strobes toward the arbiter.

The address map has four windows, and each window base is a parameter:
- a priority table with one word per source;
- a read-only view of the pending bits, 32 sources per word;
- an enable window with a power-of-two stride per target;
- a context window, also with a power-of-two stride per target, holding the threshold word and the claim/complete word.

Sources are numbered from 1. Source 0 is the "no interrupt" ID.

The bus is valid/ready on both the request side and the response side, and at most one response is outstanding. The request side is ready whenever the response register is empty or is being drained in the same cycle. An accepted request produces its response in the next cycle. The response then stays valid and unchanged until the master raises `rsp_ready`.

Top module: `irq_reg_front`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. Each accepted request yields exactly one response, with `rsp_valid` high in the following cycle. While `rsp_valid && !rsp_ready`, `rsp_valid`, `rsp_rdata` and `rsp_err` hold their values and no new request is accepted.
- R2: A request whose `req_addr[1:0]` is not `2'b00` responds with `rsp_err=1` and `rsp_rdata=0`. It changes no register and pulses no strobe.
- R3: The word at `PRIO_BASE + 4*N`, for N < NSRC, holds the priority of source N+1. A write stores `req_wdata[2:0]`, and a read returns that value zero-extended. Source s appears at `prio_flat[(s-1)*3 +: 3]`.
- R4: A read of word w of the pending window returns, in bit k, the pending input of source 32*w+k, where `pend_in[i]` is source i+1. Bit 0 of word 0 reads 0. A write to this window responds with an error and changes nothing.
- R5: In the enable window, the target is the offset divided by `EN_STRIDE`, and the word is (offset mod `EN_STRIDE`)/4. Bit k of word w enables source 32*w+k, and source s of target t appears at `en_flat[t*NSRC + s-1]`. A word index of NWORDS or more is an error with no effect.
- R6: Context offset 0 is the threshold. A read returns it. A write stores `req_wdata[2:0]` only when the whole 32-bit value is at most `MAX_PRIO`. A larger value is dropped with no error.
- R7: A read of context offset 4 pulses `claim_stb` in the acceptance cycle, with `stb_tgt` set to the target. The response carries the `claim_id` value present in that same cycle, with no error.
- R8: A write of context offset 4 with a value of at most NSRC pulses `cmpl_stb` in the acceptance cycle, with `stb_tgt` and `cmpl_id = req_wdata[5:0]`. A larger value gives no strobe and no error.
- R9: Any other aligned address, inside or outside the windows, responds with an error and read data 0. It has no effect.
- R10: After reset, all priorities, enables and thresholds are 0, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access was invalid |
| pend_in | input | NSRC | Pending bits of sources 1..NSRC |
| claim_id | input | ID_W | Arbiter's winning ID for `stb_tgt` |
| claim_stb | output | 1 | Claim request toward the arbiter |
| cmpl_stb | output | 1 | Complete request toward the arbiter |
| stb_tgt | output | TGT_W | Target of either strobe |
| cmpl_id | output | ID_W | ID being completed |
| prio_flat | output | NSRC*PRIO_W | Priority of every source |
| en_flat | output | NTGT*NSRC | Enable bits per target |
| thr_flat | output | NTGT*PRIO_W | Threshold per target |

## Verification
The assertions check several properties on every cycle:
- a stalled response stays stable;
- misaligned and invalid accesses answer with zero data;
- a claim response returns the ID seen during the strobe;
- a complete strobe only carries an in-range ID;
- a priority write keeps the low bits;
- an over-range threshold write leaves the threshold unchanged.

Only the bench scenarios can show the address arithmetic at work. That covers which source a priority word reaches, the pending bit packing with source 0 cleared, the enable stride and word split, out-of-range word indices, and the holes between windows. The bench checks all of these against its own register model, both at the read port and at the flat outputs.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic [2:0] {
    AK_NONE,
    AK_PRIO,
    AK_PEND,
    AK_ENA,
    AK_THR,
    AK_CLAIM
  } acc_kind_e;
endpackage

// File: rtl/irqf_decode.sv
module irqf_decode
  import irqf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned NSRC       = 40,
  parameter int unsigned NTGT       = 2,
  parameter int unsigned NWORDS     = 2,
  parameter int unsigned SLOT_W     = 6,
  parameter int unsigned WI_W       = 1,
  parameter int unsigned TGT_W      = 1,
  parameter logic [ADDR_W-1:0] PRIO_BASE = '0,
  parameter logic [ADDR_W-1:0] PEND_BASE = '0,
  parameter logic [ADDR_W-1:0] EN_BASE   = '0,
  parameter int unsigned EN_STRIDE  = 128,
  parameter logic [ADDR_W-1:0] CTX_BASE  = '0,
  parameter int unsigned CTX_STRIDE = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [SLOT_W-1:0] slot,
  output logic [WI_W-1:0]   word,
  output logic [TGT_W-1:0]  tgt
);
  localparam int unsigned EN_SH  = $clog2(EN_STRIDE);
  localparam int unsigned CTX_SH = $clog2(CTX_STRIDE);
  localparam logic [ADDR_W-1:0] PRIO_SPAN = ADDR_W'(NSRC * 4);
  localparam logic [ADDR_W-1:0] PEND_SPAN = ADDR_W'(NWORDS * 4);
  localparam logic [ADDR_W-1:0] EN_SPAN   = ADDR_W'(NTGT * EN_STRIDE);
  localparam logic [ADDR_W-1:0] CTX_SPAN  = ADDR_W'(NTGT * CTX_STRIDE);
  localparam logic [ADDR_W-1:0] EN_MASK   = ADDR_W'(EN_STRIDE - 1);
  localparam logic [ADDR_W-1:0] CTX_MASK  = ADDR_W'(CTX_STRIDE - 1);

  always_comb begin
    kind = AK_NONE;
    slot = SLOT_W'((addr - PRIO_BASE) >> 2);
    word = '0;
    tgt  = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr >= PRIO_BASE && (addr - PRIO_BASE) < PRIO_SPAN) begin
        kind = AK_PRIO;
      end else if (addr >= PEND_BASE && (addr - PEND_BASE) < PEND_SPAN) begin
        kind = AK_PEND;
        word = WI_W'((addr - PEND_BASE) >> 2);
      end else if (addr >= EN_BASE && (addr - EN_BASE) < EN_SPAN) begin
        tgt = TGT_W'((addr - EN_BASE) >> EN_SH);
        if ((((addr - EN_BASE) & EN_MASK) >> 2) < ADDR_W'(NWORDS)) begin
          kind = AK_ENA;
          word = WI_W'(((addr - EN_BASE) & EN_MASK) >> 2);
        end
      end else if (addr >= CTX_BASE && (addr - CTX_BASE) < CTX_SPAN) begin
        tgt = TGT_W'((addr - CTX_BASE) >> CTX_SH);
        if (((addr - CTX_BASE) & CTX_MASK) == ADDR_W'(0)) kind = AK_THR;
        else if (((addr - CTX_BASE) & CTX_MASK) == ADDR_W'(4)) kind = AK_CLAIM;
      end
    end
  end
endmodule

// File: rtl/irqf_prio_tab.sv
module irqf_prio_tab #(
  parameter int unsigned NSRC   = 40,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned SLOT_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SLOT_W-1:0]        slot,
  input  logic [PRIO_W-1:0]        wdata,
  output logic [PRIO_W-1:0]        rd,
  output logic [NSRC*PRIO_W-1:0]   prio_flat
);
  logic [PRIO_W-1:0] tab_q [NSRC];

  for (genvar n = 0; n < NSRC; n++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               tab_q[n] <= '0;
      else if (we && slot == SLOT_W'(n))        tab_q[n] <= wdata;
    end
    assign prio_flat[n*PRIO_W +: PRIO_W] = tab_q[n];
  end

  assign rd = tab_q[slot];

  // R3: the written slot holds the truncated write data one cycle later
  p_prio_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tab_q[$past(slot)] == $past(wdata));
endmodule

// File: rtl/irqf_tgt_bank.sv
module irqf_tgt_bank #(
  parameter int unsigned NSRC     = 40,
  parameter int unsigned NTGT     = 2,
  parameter int unsigned NWORDS   = 2,
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned MAX_PRIO = 7,
  parameter int unsigned TGT_W    = 1,
  parameter int unsigned WI_W     = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_we,
  input  logic                     thr_we,
  input  logic [TGT_W-1:0]         tgt,
  input  logic [WI_W-1:0]          word,
  input  logic [31:0]              wdata,
  output logic [31:0]              en_rd,
  output logic [PRIO_W-1:0]        thr_rd,
  output logic [NTGT*NSRC-1:0]     en_flat,
  output logic [NTGT*PRIO_W-1:0]   thr_flat
);
  localparam int unsigned EN_BITS = NWORDS * 32;

  logic [EN_BITS-1:0] en_q  [NTGT];
  logic [PRIO_W-1:0]  thr_q [NTGT];
  logic               thr_ok;

  assign thr_ok = (wdata <= 32'(MAX_PRIO));

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[t]  <= '0;
        thr_q[t] <= '0;
      end else begin
        if (en_we && tgt == TGT_W'(t))
          en_q[t][32*word +: 32] <= wdata;
        if (thr_we && tgt == TGT_W'(t) && thr_ok)
          thr_q[t] <= PRIO_W'(wdata);
      end
    end
    assign en_flat[t*NSRC +: NSRC]      = en_q[t][NSRC:1];
    assign thr_flat[t*PRIO_W +: PRIO_W] = thr_q[t];

    // R6: an over-range threshold write leaves the threshold unchanged
    p_thr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_we && tgt == TGT_W'(t) && wdata > 32'(MAX_PRIO)) |=> $stable(thr_q[t]));
  end

  assign en_rd  = en_q[tgt][32*word +: 32];
  assign thr_rd = thr_q[tgt];
endmodule

// File: rtl/irq_reg_front.sv
module irq_reg_front
  import irqf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned NSRC       = 40,
  parameter int unsigned NTGT       = 2,
  parameter int unsigned PRIO_W     = 3,
  parameter int unsigned MAX_PRIO   = 7,
  parameter logic [ADDR_W-1:0] PRIO_BASE = 24'h00_0000,
  parameter logic [ADDR_W-1:0] PEND_BASE = 24'h00_1000,
  parameter logic [ADDR_W-1:0] EN_BASE   = 24'h00_2000,
  parameter int unsigned EN_STRIDE  = 128,
  parameter logic [ADDR_W-1:0] CTX_BASE  = 24'h20_0000,
  parameter int unsigned CTX_STRIDE = 4096,
  localparam int unsigned NWORDS = (NSRC + 32) / 32,
  localparam int unsigned ID_W   = $clog2(NSRC + 1),
  localparam int unsigned TGT_W  = (NTGT > 1) ? $clog2(NTGT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [31:0]              rsp_rdata,
  output logic                     rsp_err,
  input  logic [NSRC-1:0]          pend_in,
  input  logic [ID_W-1:0]          claim_id,
  output logic                     claim_stb,
  output logic                     cmpl_stb,
  output logic [TGT_W-1:0]         stb_tgt,
  output logic [ID_W-1:0]          cmpl_id,
  output logic [NSRC*PRIO_W-1:0]   prio_flat,
  output logic [NTGT*NSRC-1:0]     en_flat,
  output logic [NTGT*PRIO_W-1:0]   thr_flat
);
  localparam int unsigned SLOT_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int unsigned WI_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  acc_kind_e          kind;
  logic [SLOT_W-1:0]  slot;
  logic [WI_W-1:0]    word;
  logic               acc, bad;
  logic [PRIO_W-1:0]  prio_rd, thr_rd;
  logic [31:0]        en_rd, rd_val;
  logic [NWORDS*32-1:0] pend_vec;

  irqf_decode #(
    .ADDR_W(ADDR_W), .NSRC(NSRC), .NTGT(NTGT), .NWORDS(NWORDS),
    .SLOT_W(SLOT_W), .WI_W(WI_W), .TGT_W(TGT_W),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
    .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
    .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_dec (
    .addr(req_addr), .kind(kind), .slot(slot), .word(word), .tgt(stb_tgt)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign bad       = (kind == AK_NONE) || (kind == AK_PEND && req_write);

  irqf_prio_tab #(.NSRC(NSRC), .PRIO_W(PRIO_W), .SLOT_W(SLOT_W)) u_prio (
    .clk(clk), .rst_n(rst_n),
    .we(acc && req_write && kind == AK_PRIO),
    .slot(slot), .wdata(req_wdata[PRIO_W-1:0]),
    .rd(prio_rd), .prio_flat(prio_flat)
  );

  irqf_tgt_bank #(
    .NSRC(NSRC), .NTGT(NTGT), .NWORDS(NWORDS), .PRIO_W(PRIO_W),
    .MAX_PRIO(MAX_PRIO), .TGT_W(TGT_W), .WI_W(WI_W)
  ) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .en_we(acc && req_write && kind == AK_ENA),
    .thr_we(acc && req_write && kind == AK_THR),
    .tgt(stb_tgt), .word(word), .wdata(req_wdata),
    .en_rd(en_rd), .thr_rd(thr_rd),
    .en_flat(en_flat), .thr_flat(thr_flat)
  );

  always_comb begin
    pend_vec = '0;
    pend_vec[NSRC:1] = pend_in;
  end

  always_comb begin
    unique case (kind)
      AK_PRIO:  rd_val = 32'(prio_rd);
      AK_PEND:  rd_val = pend_vec[32*word +: 32];
      AK_ENA:   rd_val = en_rd;
      AK_THR:   rd_val = 32'(thr_rd);
      AK_CLAIM: rd_val = 32'(claim_id);
      default:  rd_val = '0;
    endcase
  end

  assign claim_stb = acc && !req_write && kind == AK_CLAIM;
  assign cmpl_stb  = acc && req_write && kind == AK_CLAIM &&
                     (req_wdata <= 32'(NSRC));
  assign cmpl_id   = req_wdata[ID_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_err   <= bad;
      rsp_rdata <= (req_write || bad) ? 32'h0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R1: a stalled response does not move
  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R2: misaligned accesses answer with an error and zero data
  p_misalign_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[1:0] != 2'b00) |=>
      (rsp_valid && rsp_err && rsp_rdata == 32'h0));

  // R7: a claim returns the ID offered during the strobe cycle
  p_claim_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |=> (rsp_valid && !rsp_err && rsp_rdata == 32'($past(claim_id))));

  // R8: completes only carry IDs in range
  p_cmpl_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_stb |-> (req_wdata <= 32'(NSRC) && !claim_stb));

  // R9: error responses carry zero data
  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));
endmodule

// File: tb/sim_irq_reg_front.sv
module sim_irq_reg_front;
  localparam int CLK_P  = 10;
  localparam int NSRC   = 40;
  localparam int NTGT   = 2;
  localparam int NW     = 2;
  localparam int ID_W   = 6;
  localparam int MAXP   = 7;
  localparam int PB     = 'h0;
  localparam int PDB    = 'h1000;
  localparam int EB     = 'h2000;
  localparam int ES     = 128;
  localparam int CB     = 'h20_0000;
  localparam int CS     = 4096;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [NSRC-1:0] pend_in = '0;
  logic [ID_W-1:0] claim_id = '0;
  logic req_ready, rsp_valid, rsp_err, claim_stb, cmpl_stb;
  logic [31:0] rsp_rdata;
  logic [0:0] stb_tgt;
  logic [ID_W-1:0] cmpl_id;
  logic [NSRC*3-1:0] prio_flat;
  logic [NTGT*NSRC-1:0] en_flat;
  logic [NTGT*3-1:0] thr_flat;

  irq_reg_front u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .pend_in(pend_in), .claim_id(claim_id),
    .claim_stb(claim_stb), .cmpl_stb(cmpl_stb), .stb_tgt(stb_tgt),
    .cmpl_id(cmpl_id), .prio_flat(prio_flat), .en_flat(en_flat),
    .thr_flat(thr_flat)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [2:0]  m_prio [NSRC];
  logic [31:0] m_en   [NTGT][NW];
  logic [2:0]  m_thr  [NTGT];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pend_word(input int w);
    logic [63:0] v;
    v = 64'({pend_in, 1'b0});
    return v[w*32 +: 32];
  endfunction

  // reference model of the register map
  function automatic void model(input bit wr, input logic [23:0] a, input logic [31:0] d,
                                input logic [ID_W-1:0] cid,
                                output logic [31:0] rd, output bit e, output bit cs,
                                output bit cc, output int et, output string tag);
    int ai, t, w, o;
    ai = int'(a);
    rd = 0; e = 0; cs = 0; cc = 0; et = 0; tag = "R9";
    if (a[1:0] != 2'b00) begin
      e = 1; tag = "R2";
    end else if (ai >= PB && ai < PB + NSRC*4) begin
      tag = "R3";
      if (wr) m_prio[(ai-PB)/4] = d[2:0];
      else rd = 32'(m_prio[(ai-PB)/4]);
    end else if (ai >= PDB && ai < PDB + NW*4) begin
      tag = "R4";
      if (wr) e = 1; else rd = pend_word((ai-PDB)/4);
    end else if (ai >= EB && ai < EB + NTGT*ES) begin
      tag = "R5";
      t = (ai-EB)/ES; w = ((ai-EB)%ES)/4;
      if (w >= NW) e = 1;
      else if (wr) m_en[t][w] = d;
      else rd = m_en[t][w];
    end else if (ai >= CB && ai < CB + NTGT*CS) begin
      t = (ai-CB)/CS; o = (ai-CB)%CS; et = t;
      if (o == 0) begin
        tag = "R6";
        if (wr) begin if (d <= 32'(MAXP)) m_thr[t] = d[2:0]; end
        else rd = 32'(m_thr[t]);
      end else if (o == 4) begin
        if (wr) begin tag = "R8"; cc = (d <= 32'(NSRC)); end
        else begin tag = "R7"; cs = 1; rd = 32'(cid); end
      end else e = 1;
    end else e = 1;
  endfunction

  task automatic do_op(input bit wr, input logic [23:0] a, input logic [31:0] d);
    logic [31:0] erd; bit ee, ecs, ecc; int et; string tag;
    logic [ID_W-1:0] cid;
    @(negedge clk);
    cid = ID_W'($urandom);
    claim_id = cid;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    model(wr, a, d, cid, erd, ee, ecs, ecc, et, tag);
    #1;
    chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 1);
    chk(claim_stb === ecs, {tag, " claim_stb"}, 32'(claim_stb), 32'(ecs));
    chk(cmpl_stb === ecc, {tag, " cmpl_stb"}, 32'(cmpl_stb), 32'(ecc));
    if (ecs || ecc) chk(32'(stb_tgt) == 32'(et), {tag, " stb_tgt"}, 32'(stb_tgt), 32'(et));
    if (ecc) chk(cmpl_id == d[ID_W-1:0], "R8 cmpl_id", 32'(cmpl_id), 32'(d[ID_W-1:0]));
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R1 rsp_valid", 32'(rsp_valid), 1);
    chk(rsp_err === ee, {tag, " err"}, 32'(rsp_err), 32'(ee));
    chk(rsp_rdata === erd, {tag, " rdata"}, rsp_rdata, erd);
  endtask

  task automatic check_flats(input string where);
    for (int s = 0; s < NSRC; s++)
      chk(prio_flat[s*3 +: 3] == m_prio[s], {"R3 prio_flat ", where}, 32'(prio_flat[s*3 +: 3]), 32'(m_prio[s]));
    for (int t = 0; t < NTGT; t++) begin
      chk(thr_flat[t*3 +: 3] == m_thr[t], {"R6 thr_flat ", where}, 32'(thr_flat[t*3 +: 3]), 32'(m_thr[t]));
      for (int s = 1; s <= NSRC; s++)
        chk(en_flat[t*NSRC + s-1] == m_en[t][s/32][s%32], {"R5 en_flat ", where},
            32'(en_flat[t*NSRC + s-1]), 32'(m_en[t][s/32][s%32]));
    end
  endtask

  function automatic logic [23:0] rand_addr();
    int r, t;
    r = int'($urandom % 7);
    t = int'($urandom % 3);
    case (r)
      0, 1: return 24'(PB + int'($urandom % (NSRC + 2)) * 4);
      2:    return 24'(PDB + int'($urandom % 4) * 4);
      3:    return 24'(EB + t*ES + int'($urandom % 4) * 4);
      4:    return 24'(CB + t*CS + int'($urandom % 4) * 4);
      5:    return 24'(PB + int'($urandom % 64) * 4 + 1 + int'($urandom % 3));
      default: return 24'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=%0h expected=%0h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    for (int s = 0; s < NSRC; s++) m_prio[s] = '0;
    for (int t = 0; t < NTGT; t++) begin
      m_thr[t] = '0;
      for (int w = 0; w < NW; w++) m_en[t][w] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(rsp_valid === 1'b0, "R10 rsp_valid", 32'(rsp_valid), 0);
    chk(req_ready === 1'b1, "R10 req_ready", 32'(req_ready), 1);
    check_flats("reset R10");

    // directed corner cases
    pend_in = 40'hA5_0000_0F03;
    do_op(0, 24'h000002, 0);                 // R2 misaligned read
    do_op(1, 24'h000005, 32'h7);             // R2 misaligned write, no effect
    do_op(1, 24'h000000, 32'hFFFF_FFFD);     // R3 slot 0 -> source 1, low bits kept
    do_op(1, 24'(PB + (NSRC-1)*4), 32'h6);   // R3 last source
    do_op(0, 24'h000000, 0);
    do_op(0, 24'(PB + NSRC*4), 0);           // R9 just past priority window
    do_op(0, 24'(PDB), 0);                   // R4 word 0, source 0 bit clear
    do_op(0, 24'(PDB + 4), 0);               // R4 word 1
    do_op(1, 24'(PDB), 32'hFFFF_FFFF);       // R4 write rejected
    do_op(1, 24'(EB + ES + 4), 32'h1234_5678); // R5 target 1 word 1
    do_op(0, 24'(EB + ES + 4), 0);
    do_op(1, 24'(EB + 8), 32'hFFFF_FFFF);    // R5 word index beyond bitmap
    do_op(1, 24'(CB + CS), 32'h5);           // R6 target 1 threshold
    do_op(1, 24'(CB + CS), 32'h8);           // R6 over max dropped
    do_op(0, 24'(CB + CS), 0);
    do_op(0, 24'(CB + 4), 0);                // R7 claim target 0
    do_op(1, 24'(CB + CS + 4), 32'd40);      // R8 last valid ID
    do_op(1, 24'(CB + 4), 32'd41);           // R8 out of range, ignored
    do_op(0, 24'(CB + 8), 0);                // R9 other context offset
    do_op(0, 24'h10_0000, 0);                // R9 unmapped
    check_flats("directed");

    // R1 back-pressure: response held, new request not accepted
    do_op(1, 24'h000000, 32'h3);
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 24'h000000; req_wdata = 0;
    @(posedge clk);
    @(negedge clk);
    req_write = 1; req_wdata = 32'h5;
    held = rsp_rdata;
    chk(held == 32'h3, "R1 stalled data", held, 3);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(rsp_valid === 1'b1 && req_ready === 1'b0, "R1 stall flags",
          {30'b0, rsp_valid, req_ready}, 32'h2);
      chk(rsp_rdata === held, "R1 stall stable", rsp_rdata, held);
      @(negedge clk);
    end
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 drained", 32'(rsp_valid), 0);
    do_op(0, 24'h000000, 0);                 // still 3: stalled write never accepted

    // constrained random traffic
    for (int i = 0; i < 600; i++) begin
      if (i % 16 == 0) pend_in = {8'($urandom), 32'($urandom)};
      do_op(1'($urandom), rand_addr(),
            ($urandom % 2) ? $urandom : ($urandom % 48));
    end
    check_flats("random");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule